// File: doc/BRIEF.md
# Serialized Interrupt Slave Controller

This block sits on the peripheral side of a one-wire serialized interrupt bus that shares its clock with a low-pin-count host link. The wire is active low and open drain with a pull-up. The block samples it on every rising clock edge and follows each transfer cycle. A cycle opens with a start frame, carries seventeen data frames of three states each, and closes with a stop frame. In the first state of each data frame, the block pulls the wire low when that frame's request input is high and its enable bit is set.

The width of the stop pulse sets the mode of the next cycle. In continuous mode only the host opens cycles. In quiet mode, an idle block with an enabled request pending may pull the wire low for a single state, and the host then finishes the start pulse. The block presents only a drive-low enable for the wire and a flag for the current mode.

Top module: `sirq_slave`

## Requirements
- R1: After reset the mode flag is 0 (continuous) and the drive enable is 0.
- R2: A start is a run of at least 4 consecutive low states followed by a high state. One turnaround state follows that high state, and then the first state of data frame 0 begins.
- R3: A low run of fewer than 4 states while idle is ignored and does not shift the alignment of a later start.
- R4: Data frame k (k = 0..16, in bus order IRQ0, IRQ1, SMI, IRQ3 to IRQ15, IOCHCK, held in bit k of the request and enable inputs) begins 3k states after frame 0 begins. The block drives low in the first state of frame k when request bit k and enable bit k are both 1, and never in the second or third state.
- R5: A frame whose enable bit is 0 is never driven, and a request on that frame cannot start a cycle.
- R6: In the stop frame, a low pulse of exactly 2 states sets quiet mode (flag 1) and a pulse of 3 or more states sets continuous mode (flag 0). The flag changes on the first high state after the pulse. A 1-state pulse is ignored and the block keeps waiting for a stop pulse.
- R7: When idle in quiet mode with an enabled request pending, the block drives the wire low for exactly one state. It does not do so again until a cycle has started.
- R8: When idle in continuous mode, the block never drives the wire.
- R9: The drive enable is never high in two consecutive states.
- R10: A request raised after its own frame has passed in the current cycle is not reported in any other frame of that cycle. It is reported in its own frame of the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | 1 | Sampled level of the serialized interrupt wire |
| irq_req | input | 17 | Request per data frame, bit k = frame k |
| slot_en | input | 17 | Enable per data frame, bit k = frame k |
| line_oe_lo | output | 1 | Drive the wire low while high |
| quiet_o | output | 1 | Current mode: 1 quiet, 0 continuous |

## Verification
Data frames are run with every request set, with alternating bits, with only SMI or only IOCHCK set, and with start pulses of 4 and 6 states. The single-bit patterns reveal an off-by-one in frame position. The two start widths show whether alignment comes from the rising edge of the wire rather than from the pulse length. A mask of zero under full requests separates gating by enable from gating by request. Stop pulses of 1, 2 and 3 states, a self-start with enabled and with masked requests, and a request raised after its frame has passed cover the mode logic and the rule of one frame per request.

// File: rtl/sirq_slave.sv
module sirq_slave #(
  parameter int NSLOT     = 17,
  parameter int START_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [NSLOT-1:0] irq_req,
  input  logic [NSLOT-1:0] slot_en,
  output logic             line_oe_lo,
  output logic             quiet_o
);
  localparam int          SW   = $clog2(NSLOT);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);
  localparam logic [2:0]  SMIN = 3'(START_MIN);

  typedef enum logic [1:0] {S_IDLE, S_TA, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [SW-1:0] frm;
  logic [1:0]    ph;
  logic [2:0]    low_run;
  logic          kicked;

  wire pend     = |(irq_req & slot_en);
  wire slot_hit = (st == S_DATA) && (ph == 2'd0) && irq_req[frm] && slot_en[frm];
  wire kick     = (st == S_IDLE) && quiet_o && pend && !kicked && (low_run == 3'd0);
  wire [2:0] run_nx = (low_run == 3'd7) ? low_run : low_run + 3'd1;

  assign line_oe_lo = slot_hit | kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frm     <= '0;
      ph      <= '0;
      low_run <= '0;
      kicked  <= 1'b0;
      quiet_o <= 1'b0;
    end else begin
      low_run <= line_i ? 3'd0 : run_nx;
      case (st)
        S_IDLE: begin
          if (kick) kicked <= 1'b1;
          if (line_i && low_run >= SMIN) st <= S_TA;
        end
        S_TA: begin
          st     <= S_DATA;
          frm    <= '0;
          ph     <= '0;
          kicked <= 1'b0;
        end
        S_DATA: begin
          if (ph == 2'd2) begin
            ph <= '0;
            if (frm == LAST) st <= S_STOP;
            else frm <= frm + SW'(1);
          end else begin
            ph <= ph + 2'd1;
          end
        end
        S_STOP: begin
          if (line_i && low_run >= 3'd2) begin
            quiet_o <= (low_run == 3'd2);
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  no_double_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe_lo |=> !line_oe_lo);

  // R8
  no_cont_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && line_oe_lo) |-> quiet_o);

  // R6
  mode_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet_o) |-> $past(st) == S_STOP);

  // R2
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TA) |=> (st == S_DATA && frm == '0 && ph == 2'd0));

  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (frm <= LAST && ph != 2'd3));
endmodule

// File: tb/sirq_slave_tb_top.sv
module sirq_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_lo = 1'b0;
  logic [16:0] irq_req = '0;
  logic [16:0] slot_en = '0;
  logic        line_oe_lo, quiet_o;
  wire         line = !(host_lo | line_oe_lo);
  int          checks = 0;
  int          fails = 0;
  logic [16:0] seen;
  int          extra;

  always #4 clk = ~clk;

  sirq_slave dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .irq_req(irq_req),
    .slot_en(slot_en), .line_oe_lo(line_oe_lo), .quiet_o(quiet_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_start(input int lows);
    for (int i = 0; i < lows; i++) begin @(negedge clk); host_lo = 1'b1; end
    @(negedge clk); host_lo = 1'b0;
  endtask

  task automatic data_frames(input int raise_s, input int raise_b,
                             output logic [16:0] got, output int bad);
    got = '0; bad = 0;
    @(negedge clk);
    for (int s = 0; s < 51; s++) begin
      @(negedge clk);
      if (line_oe_lo) begin
        if (s % 3 == 0) got[s/3] = 1'b1;
        else bad++;
      end
      if (s == raise_s) irq_req[raise_b] = 1'b1;
    end
  endtask

  task automatic host_stop(input int w);
    @(negedge clk); host_lo = 1'b0;
    for (int i = 0; i < w; i++) begin @(negedge clk); host_lo = 1'b1; end
    @(negedge clk); host_lo = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    irq_req = '1; slot_en = '1;
    repeat (3) @(negedge clk);
    chk(line_oe_lo == 1'b0 && quiet_o == 1'b0, "R1 reset", {line_oe_lo, quiet_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_oe_lo == 1'b0 && quiet_o == 1'b0, "R1 after release", {line_oe_lo, quiet_o}, 0);
    irq_req = '0;
  endtask

  task automatic t_pattern(input logic [16:0] rq, input logic [16:0] en, input int lows, input string tag);
    irq_req = rq; slot_en = en;
    host_start(lows);
    data_frames(-1, 0, seen, extra);
    chk(seen == (rq & en), tag, seen, rq & en);
    chk(extra == 0, "R9 R4 drive outside sample state", extra, 0);
    host_stop(3);
    chk(quiet_o == 1'b0, "R6 three-state stop", quiet_o, 0);
  endtask

  task automatic t_short;
    irq_req = 17'h00421; slot_en = '1;
    host_start(3);
    repeat (3) @(negedge clk);
    host_start(4);
    data_frames(-1, 0, seen, extra);
    chk(seen == 17'h00421 && extra == 0, "R3 short pulse ignored", seen, 17'h00421);
    host_stop(3);
  endtask

  task automatic t_late;
    irq_req = '0; slot_en = '1;
    host_start(4);
    data_frames(4, 0, seen, extra);
    chk(seen == '0, "R10 late request not in this cycle", seen, 0);
    host_stop(3);
    host_start(4);
    data_frames(-1, 0, seen, extra);
    chk(seen == 17'h00001, "R10 late request in next cycle", seen, 1);
    host_stop(3);
    irq_req = '0;
  endtask

  task automatic t_stop_modes;
    host_start(4);
    data_frames(-1, 0, seen, extra);
    host_stop(1);
    chk(quiet_o == 1'b0, "R6 one-state stop ignored", quiet_o, 0);
    host_stop(2);
    chk(quiet_o == 1'b1, "R6 two-state stop", quiet_o, 1);
  endtask

  task automatic t_kick;
    slot_en = '1;
    irq_req = 17'h00080;
    #1;
    chk(line_oe_lo == 1'b1, "R7 quiet self-start", line_oe_lo, 1);
    @(negedge clk);
    chk(line_oe_lo == 1'b0, "R7 single start state", line_oe_lo, 0);
    host_lo = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk); host_lo = 1'b0;
    data_frames(-1, 0, seen, extra);
    chk(seen == 17'h00080 && extra == 0, "R7 cycle after self-start", seen, 17'h00080);
    irq_req = '0;
    host_stop(2);
    chk(quiet_o == 1'b1, "R6 quiet kept", quiet_o, 1);
  endtask

  task automatic t_masked_kick;
    int hits;
    hits = 0;
    slot_en = ~17'h00008; irq_req = 17'h00008;
    for (int i = 0; i < 6; i++) begin #1; if (line_oe_lo) hits++; @(negedge clk); end
    chk(hits == 0, "R5 masked request no self-start", hits, 0);
    irq_req = '1; slot_en = '0;
    host_start(4);
    data_frames(-1, 0, seen, extra);
    chk(seen == '0 && extra == 0, "R5 zero mask no drive", seen, 0);
    host_stop(3);
    chk(quiet_o == 1'b0, "R6 back to continuous", quiet_o, 0);
  endtask

  task automatic t_cont_idle;
    int hits;
    hits = 0;
    slot_en = '1; irq_req = 17'h00008;
    for (int i = 0; i < 10; i++) begin #1; if (line_oe_lo) hits++; @(negedge clk); end
    chk(hits == 0, "R8 no self-start in continuous", hits, 0);
    irq_req = '0;
  endtask

  initial begin
    t_reset();
    t_pattern(17'h1FFFF, 17'h1FFFF, 4, "R2 R4 all requests");
    t_pattern(17'h0AAAA, 17'h1FFFF, 6, "R2 R4 alternating long start");
    t_pattern(17'h00004, 17'h1FFFF, 4, "R4 SMI only");
    t_pattern(17'h10000, 17'h1FFFF, 5, "R4 IOCHCK only");
    t_pattern(17'h1FFFF, 17'h05555, 4, "R5 partial mask");
    t_short();
    t_late();
    t_stop_modes();
    t_kick();
    t_masked_kick();
    t_cont_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule